// File: doc/BRIEF.md
# Phase-Offset NCO Cosine Core

This block is a numerically controlled oscillator that produces a digital cosine. A 32-bit phase register adds a frequency word on every enabled reference clock and wraps modulo 2^32. The output frequency is therefore `tune_word * f_clk / 2^32`. A 5-bit phase offset is added into the five most significant phase bits. Its steps are binary weighted: half a turn for the top bit, down to 1/32 turn for the bottom bit. The sum is cut to a 14-bit table index. A cosine table, computed once at elaboration, turns that index into a 10-bit offset-binary sample.

The two control inputs reach the output with different fixed latencies. A new phase offset needs 13 register stages and a new frequency word needs 18. A power-down input freezes the whole datapath. A small fill controller (states FILL, RUN, SLEEP) decides when the sample is valid. It starts in FILL after reset. It moves to RUN once 13 enabled edges have passed since reset. It moves to SLEEP on any edge with power-down high, and leaves SLEEP for RUN, or for FILL if the count is not yet reached, on the first edge with power-down low.

Top module: `nco_cos_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the phase register, every delay stage and the sample. Directly after reset, `sample` is 0 and `sample_vld` is 0. With zero inputs, the first valid sample is 1023.
- R2: The phase register wraps modulo 2^32. With `tune_word` = 0x8000_0000 and no offset, valid samples alternate between 1023 and 0.
- R3: Bit k of `phase_ofs` adds 2^(27+k) to the phase, so bit 4 is a half turn. With a zero phase register, offset 16 yields sample 0.
- R4: The table index is phase bits 31:18. Phase increments below 2^18 do not change the sample until they carry into bit 18.
- R5: For table index i, the sample is round(511.5 + 511.5*cos(2*pi*(i+0.5)/16384)). This gives 1023 at index 0 and 511 at index 4096.
- R6: A tuning word captured at enabled edge j first changes the phase increment seen in the sample output after enabled edge j+17 (18 register stages).
- R7: A phase offset captured at enabled edge j first appears in the sample output after enabled edge j+12 (13 register stages).
- R8: At any edge with `pwr_down` high, nothing advances. Inputs presented at that edge are ignored, `sample` holds its value and `sample_vld` is 0 after that edge.
- R9: A change of tuning word never restarts the phase register. The phase after a change is the running sum of all captured words.
- R10: `sample_vld` is 1 after an enabled edge exactly when at least 13 enabled edges have occurred since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Freeze all state while high |
| tune_word | input | 32 | Phase increment per enabled clock |
| phase_ofs | input | 5 | Phase offset in 1/32-turn steps |
| sample | output | 10 | Offset-binary cosine sample |
| sample_vld | output | 1 | Sample valid flag |

## Verification
The most delicate overlap is a power-down edge that falls on the same cycle as other pipeline events. Those events are the completion of the 13-edge fill, or a new offset or frequency word reaching the output stage. The bench provokes this overlap with random power-down cycles mixed with random offset and tuning changes, and with a reset in the middle of a run followed by a refill. A reference model counts only enabled edges. It keeps the running sum of captured tuning words, so each cycle's expected sample comes from the word sum 17 edges back and the offset 12 edges back. Each cycle's expected valid flag comes from the edge count and the current power-down level.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } fill_state_e;
endpackage

// File: rtl/nco_delay_line.sv
module nco_delay_line #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)     stg[0] <= '0;
                else if (en) stg[0] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)     stg[g] <= '0;
                else if (en) stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32,
    parameter int OFS_W = 5,
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] step_in,
    input  logic [OFS_W-1:0] ofs_in,
    output logic [IDX_W-1:0] idx
);
    localparam int PAD_W = ACC_W - OFS_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] phase_sum;

    assign phase_sum = acc + {ofs_in, {PAD_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            idx <= '0;
        end else if (en) begin
            acc <= acc + step_in;
            idx <= phase_sum[ACC_W-1 -: IDX_W];
        end
    end
endmodule

// File: rtl/nco_cos_lut.sv
module nco_cos_lut #(
    parameter int IDX_W = 14,
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [AMP_W-1:0] sample
);
    localparam int QB      = IDX_W - 2;
    localparam int QN      = 1 << QB;
    localparam int AMP_MAX = (1 << AMP_W) - 1;
    localparam real TURN   = real'(1 << IDX_W);

    logic [AMP_W-1:0] qtab [QN];

    initial begin
        for (int i = 0; i < QN; i++) begin
            real ang;
            int  v;
            ang = 2.0 * 3.14159265358979 * (real'(i) + 0.5) / TURN;
            v   = $rtoi($floor(AMP_MAX / 2.0 + (AMP_MAX / 2.0) * $cos(ang) + 0.5));
            qtab[i] = AMP_W'(v);
        end
    end

    logic [QB-1:0]    addr_a;
    logic             neg_a, neg_b;
    logic [AMP_W-1:0] rom_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_a <= '0;
            neg_a  <= 1'b0;
            rom_b  <= '0;
            neg_b  <= 1'b0;
            sample <= '0;
        end else if (en) begin
            addr_a <= idx[IDX_W-2] ? ~idx[QB-1:0] : idx[QB-1:0];
            neg_a  <= idx[IDX_W-1] ^ idx[IDX_W-2];
            rom_b  <= qtab[addr_a];
            neg_b  <= neg_a;
            sample <= neg_b ? AMP_W'(AMP_MAX) - rom_b : rom_b;
        end
    end

    AST_COS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(en, 1) && $past(en, 2) && $past(en, 3) &&
         !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
         $past(idx, 3) == '0) |-> sample == AMP_W'(AMP_MAX)); // R5
endmodule

// File: rtl/nco_fill_fsm.sv
module nco_fill_fsm
    import nco_pkg::*;
#(
    parameter int FILL_N = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    output logic vld
);
    localparam int CW = $clog2(FILL_N + 1);

    fill_state_e    state, state_nx;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (!pwr_down && cnt != CW'(FILL_N)) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: begin
                if (pwr_down)                    state_nx = ST_SLEEP;
                else if (cnt >= CW'(FILL_N - 1)) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (pwr_down) state_nx = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (!pwr_down)
                    state_nx = (cnt >= CW'(FILL_N - 1)) ? ST_RUN : ST_FILL;
            end
            default: state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        vld = (state == ST_RUN);
    end

    AST_VLD_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        $rose(vld) |-> $past(cnt) >= CW'(FILL_N - 1)); // R10
endmodule

// File: rtl/nco_cos_core.sv
module nco_cos_core #(
    parameter int ACC_W     = 32,
    parameter int OFS_W     = 5,
    parameter int IDX_W     = 14,
    parameter int AMP_W     = 10,
    parameter int PHASE_LAT = 13,
    parameter int FREQ_LAT  = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic [ACC_W-1:0] tune_word,
    input  logic [OFS_W-1:0] phase_ofs,
    output logic [AMP_W-1:0] sample,
    output logic             sample_vld
);
    localparam int LUT_LAT = 3;
    localparam int OFS_DLY = PHASE_LAT - 1 - LUT_LAT;
    localparam int TW_DLY  = FREQ_LAT - 2 - LUT_LAT;

    logic             en;
    logic [ACC_W-1:0] tw_late;
    logic [OFS_W-1:0] ofs_late;
    logic [IDX_W-1:0] idx;

    assign en = ~pwr_down;

    nco_delay_line #(.W(ACC_W), .DEPTH(TW_DLY)) u_tw_dly (
        .clk(clk), .rst(rst), .en(en), .din(tune_word), .dout(tw_late));

    nco_delay_line #(.W(OFS_W), .DEPTH(OFS_DLY)) u_ofs_dly (
        .clk(clk), .rst(rst), .en(en), .din(phase_ofs), .dout(ofs_late));

    nco_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst(rst), .en(en), .step_in(tw_late), .ofs_in(ofs_late), .idx(idx));

    nco_cos_lut #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_lut (
        .clk(clk), .rst(rst), .en(en), .idx(idx), .sample(sample));

    nco_fill_fsm #(.FILL_N(PHASE_LAT)) u_fsm (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .vld(sample_vld));

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && !rst) |=> $stable(sample)); // R8
    AST_SLEEP_NOVLD: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && !rst) |=> !sample_vld); // R8
    AST_VLD_AWAKE: assert property (@(posedge clk) disable iff (rst)
        sample_vld |-> !$past(pwr_down)); // R10
endmodule

// File: tb/nco_cos_core_test.sv
module nco_cos_core_test;
    localparam int CLK_P = 10;
    localparam int MAXE  = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_down = 1'b0;
    logic [31:0] tune_word = '0;
    logic [4:0]  phase_ofs = '0;
    logic [9:0]  sample;
    logic        sample_vld;

    int tests = 0;
    int fails = 0;
    int e = 0;
    logic [31:0] ps  [0:MAXE];
    logic [4:0]  ofh [0:MAXE];

    always #(CLK_P/2) clk = ~clk;

    nco_cos_core uut (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .tune_word(tune_word),
        .phase_ofs(phase_ofs), .sample(sample), .sample_vld(sample_vld));

    function automatic int cos_ref(int i);
        real a;
        a = 2.0 * 3.14159265358979 * (real'(i) + 0.5) / 16384.0;
        return $rtoi($floor(511.5 + 511.5 * $cos(a) + 0.5));
    endfunction

    function automatic logic [31:0] ps_at(int k);
        return (k < 1) ? 32'd0 : ps[k];
    endfunction

    function automatic logic [4:0] of_at(int k);
        return (k < 1) ? 5'd0 : ofh[k];
    endfunction

    function automatic int exp_sample(int ee);
        logic [31:0] ph;
        ph = ps_at(ee - 17) + {of_at(ee - 12), 27'b0};
        return cos_ref(int'(ph[31:18]));
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, exp, e);
        end
    endtask

    task automatic step(input logic [31:0] tw, input logic [4:0] ofs, input bit pd, input string tag);
        tune_word = tw;
        phase_ofs = ofs;
        pwr_down  = pd;
        @(posedge clk);
        if (!pd) begin
            e++;
            ofh[e] = ofs;
            ps[e]  = ps[e-1] + tw;
        end
        @(negedge clk);
        check(tag, int'(sample_vld), int'(e >= 13 && !pd), "vld");
        if (e >= 13) check(tag, int'(sample), exp_sample(e), "sample");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pwr_down = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e = 0;
        ps[0] = '0;
        check("R1", int'(sample_vld), 0, "vld after reset");
        check("R1", int'(sample), 0, "sample after reset");
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        ps[0] = '0;
        do_reset();

        // R1 / R10: fill with zero inputs
        for (int i = 0; i < 12; i++) step('0, '0, 1'b0, "R10");
        step('0, '0, 1'b0, "R10");
        check("R1", int'(sample), 1023, "first valid sample");
        for (int i = 0; i < 5; i++) step('0, '0, 1'b0, "R1");

        // R3 / R7: offsets, phase latency
        for (int i = 0; i < 13; i++) step('0, 5'd16, 1'b0, "R7");
        check("R3", int'(sample), 0, "half-turn offset");
        for (int i = 0; i < 13; i++) step('0, 5'd8, 1'b0, "R7");
        check("R5", int'(sample), 511, "quarter-turn offset");
        for (int i = 0; i < 13; i++) step('0, 5'd1, 1'b0, "R3");
        for (int i = 0; i < 13; i++) step('0, 5'd24, 1'b0, "R3");
        for (int i = 0; i < 13; i++) step('0, 5'd0, 1'b0, "R5");

        // R4: sub-index increments, then one index step per edge
        for (int i = 0; i < 40; i++) step(32'd1, '0, 1'b0, "R4");
        for (int i = 0; i < 40; i++) step(32'h0004_0000, '0, 1'b0, "R4");

        // R2: wrap with half-turn step
        for (int i = 0; i < 40; i++) step(32'h8000_0000, '0, 1'b0, "R2");
        step(32'h8000_0000, '0, 1'b0, "R2");
        check("R2", int'(sample) + 0, (int'(sample) == 0) ? 0 : 1023, "alternating extreme");

        // R6 / R9: tuning-word changes
        for (int k = 0; k < 20; k++) begin
            logic [31:0] tw;
            tw = $urandom();
            for (int i = 0; i < 25; i++) step(tw, '0, 1'b0, (k % 2 == 0) ? "R6" : "R9");
        end

        // R8: random power-down mixed with input changes
        for (int i = 0; i < 600; i++) begin
            step($urandom(), 5'($urandom()), ($urandom_range(0, 4) == 0), "R8");
        end

        // R1 / R8 / R10: reset mid-run, power-down during fill
        do_reset();
        for (int i = 0; i < 40; i++) begin
            step($urandom(), 5'($urandom()), ($urandom_range(0, 2) == 0), "R10");
        end
        for (int i = 0; i < 5; i++) step(32'h1234_5678, 5'd3, 1'b1, "R8");
        for (int i = 0; i < 300; i++) begin
            step($urandom(), 5'($urandom()), ($urandom_range(0, 6) == 0), "R9");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule